// File: doc/BRIEF.md
# Bus-Stuck Timeout Monitor

This block watches the synchronized clock and data levels of a two-wire serial slave while its protocol engine reports a transaction in progress. It has one timer for each line. When an armed line stays low for longer than a programmed interval, the block raises a single-cycle abort pulse. The protocol engine uses that pulse to release its data driver and go back to waiting for a start condition. This stops a master that stalls mid-transfer from hanging the slave indefinitely.

Two bits of a shared configuration byte arm each line on its own. Bit 7 arms clock-stuck detection and bit 6 arms data-stuck detection. The register that holds this byte resets to zero, so both detectors are off until software turns them on. The interval is the product of two parameters: a prescaler period in system clocks and a count of prescaler ticks. The defaults give 25 ms at a 250 MHz clock.

Top module: `bus_stuck_timeout`

## Requirements
- R1: While rst_ni is low, abort_o is low, and every timer starts from zero when reset is released.
- R2: cfg_i bit 7 arms the clock-line timer. While that bit is 0, a low scl_i never causes an abort, and clearing the bit restarts the clock-line count.
- R3: cfg_i bit 6 arms the data-line timer. While that bit is 0, a low sda_i never causes an abort.
- R4: Let N = TICK_DIV*TIMEOUT_TICKS. Count the rising clock edges at which an armed line is sampled low while busy_i is high. abort_o goes high for one cycle right after the N-th such consecutive edge.
- R5: While busy_i is low, both timers are held at zero and abort_o stays low.
- R6: A single sampled high level on a monitored line restarts that line's count from zero.
- R7: One unbroken low period produces at most one abort pulse, however long it lasts.
- R8: If both armed lines go low together, exactly one abort pulse is produced, with the R4 timing.
- R9: cfg_i bits 5 to 0 have no effect on the abort output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | High while the protocol engine is inside a transaction |
| scl_i | input | 1 | Synchronized clock-line level |
| sda_i | input | 1 | Synchronized data-line level |
| cfg_i | input | 8 | Configuration byte; bit 7 arms the clock timer, bit 6 arms the data timer |
| abort_o | output | 1 | One-cycle request to return the slave interface to idle |

## Verification
The bench builds the block with TICK_DIV=4 and TIMEOUT_TICKS=3, which gives a 12-cycle window. With a window that short, every combination of the two arm bits, the three stuck-line patterns and the busy level can be swept. Each combination is held for one cycle short of the window, exactly the window, and three windows, so the boundary cycle and the single-pulse rule are both checked. The same small window lets a one-cycle high glitch, an arm bit dropped for one cycle and a varied lower configuration field each be placed at a chosen point inside a count.

// File: rtl/bto_pkg.sv
package bto_pkg;
  localparam int unsigned NUM_LINES  = 2;
  localparam int unsigned CFG_W      = 8;
  localparam int unsigned LINE_SCL   = 0;
  localparam int unsigned LINE_SDA   = 1;
  localparam int unsigned EN_BIT_SCL = 7;
  localparam int unsigned EN_BIT_SDA = 6;
endpackage

// File: rtl/bto_prescale.sv
module bto_prescale #(
  parameter int unsigned DIV = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == W'(DIV - 1));
  assign tick_o = run_i && !clr_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bto_watch.sv
module bto_watch #(
  parameter int unsigned DIV   = 250000,
  parameter int unsigned TICKS = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic busy_i,
  input  logic line_i,
  output logic hit_o
);
  localparam int unsigned TW = $clog2(TICKS + 1);

  logic          run, clr, tick, expire;
  logic [TW-1:0] tcnt_q;
  logic          fired_q, hit_q;

  // count only while armed, in a transaction and held low
  assign run = en_i && busy_i && !line_i;
  assign clr = !run;

  bto_prescale #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .run_i (run),
    .tick_o(tick)
  );

  assign expire = tick && !fired_q && (tcnt_q == TW'(TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q  <= '0;
      fired_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= expire;
      if (clr) begin
        tcnt_q  <= '0;
        fired_q <= 1'b0;
      end else if (expire) begin
        tcnt_q  <= '0;
        fired_q <= 1'b1;  // hold off until the line is released
      end else if (tick && !fired_q) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/bus_stuck_timeout.sv
module bus_stuck_timeout
  import bto_pkg::*;
#(
  parameter int unsigned TICK_DIV      = 250000,
  parameter int unsigned TIMEOUT_TICKS = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             abort_o
);
  logic [NUM_LINES-1:0] lines, ens, hits;
  logic                 hit_scl, hit_sda;
  logic                 unused_cfg;

  assign lines[LINE_SCL] = scl_i;
  assign lines[LINE_SDA] = sda_i;
  assign ens[LINE_SCL]   = cfg_i[EN_BIT_SCL];
  assign ens[LINE_SDA]   = cfg_i[EN_BIT_SDA];
  assign unused_cfg      = ^cfg_i[5:0];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    bto_watch #(.DIV(TICK_DIV), .TICKS(TIMEOUT_TICKS)) u_watch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ens[i]),
      .busy_i(busy_i),
      .line_i(lines[i]),
      .hit_o (hits[i])
    );
  end

  assign hit_scl = hits[LINE_SCL];
  assign hit_sda = hits[LINE_SDA];
  assign abort_o = |hits;
endmodule

// File: rtl/bto_checker.sv
module bto_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       scl_i,
  input logic       sda_i,
  input logic [7:0] cfg_i,
  input logic       abort_o,
  input logic       hit_scl_i,
  input logic       hit_sda_i
);
  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!abort_o); // R1
  end

  AST_SCL_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[7] |=> !hit_scl_i); // R2
  AST_SDA_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[6] |=> !hit_sda_i); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !abort_o); // R5
  AST_HIGH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && sda_i) |=> !abort_o); // R6
  AST_SCL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_scl_i |=> !hit_scl_i); // R7
  AST_SDA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_sda_i |=> !hit_sda_i); // R7
endmodule

bind bus_stuck_timeout bto_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_i),
  .scl_i    (scl_i),
  .sda_i    (sda_i),
  .cfg_i    (cfg_i),
  .abort_o  (abort_o),
  .hit_scl_i(hit_scl),
  .hit_sda_i(hit_sda)
);

// File: tb/sim_bus_stuck_timeout.sv
`timescale 1ns/1ps
module sim_bus_stuck_timeout;
  localparam int DIV = 4;
  localparam int TK  = 3;
  localparam int N   = DIV * TK;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       busy_i = 1'b0, scl_i = 1'b1, sda_i = 1'b1;
  logic [7:0] cfg_i = 8'h00;
  logic       abort_o;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bus_stuck_timeout #(.TICK_DIV(DIV), .TIMEOUT_TICKS(TK)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .busy_i(busy_i), .scl_i(scl_i),
    .sda_i(sda_i), .cfg_i(cfg_i), .abort_o(abort_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a level pattern for cyc cycles; called 1 ns after a rising edge
  task automatic seg(input logic scl, input logic sda, input logic b,
                     input logic [7:0] c, input int cyc,
                     output int pulses, output int first);
    scl_i = scl; sda_i = sda; busy_i = b; cfg_i = c;
    pulses = 0; first = 0;
    for (int k = 1; k <= cyc; k++) begin
      @(posedge clk); #1;
      if (abort_o) begin
        pulses++;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int p, f;
    int holds[3];
    holds[0] = N - 1; holds[1] = N; holds[2] = 3 * N;
    #7;
    chk("R1 abort low in reset", int'(abort_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 abort low after reset", int'(abort_o), 0);

    // sweep: arm bits (R2 R3), stuck pattern (R8), busy (R5), hold length (R4 R7), low cfg bits (R9)
    for (int e = 0; e < 4; e++)
      for (int s = 1; s < 4; s++)
        for (int b = 0; b < 2; b++)
          for (int h = 0; h < 3; h++) begin
            logic [7:0] c;
            bit armed;
            int ep, ef;
            c = {e[1:0], 6'((s * 21 + b * 7 + h * 11) & 63)};
            armed = (b == 1) && ((s[0] && e[1]) || (s[1] && e[0]));
            ep = (armed && holds[h] >= N) ? 1 : 0;
            ef = ep ? N : 0;
            seg(!s[0], !s[1], b[0], c, holds[h], p, f);
            chk("R2 R3 R4 R5 R7 R8 R9 pulse count", p, ep);
            chk("R4 pulse cycle", f, ef);
            seg(1'b1, 1'b1, 1'b0, c, 3, p, f);
            chk("R5 idle quiet", p, 0);
          end

    // R6: one-cycle high glitch restarts the count
    seg(1'b0, 1'b1, 1'b1, 8'h80, N - 1, p, f);
    chk("R6 no pulse before glitch", p, 0);
    seg(1'b1, 1'b1, 1'b1, 8'h80, 1, p, f);
    seg(1'b0, 1'b1, 1'b1, 8'h80, 2 * N, p, f);
    chk("R6 restart pulse cycle", f, N);
    chk("R6 single after restart", p, 1);
    seg(1'b1, 1'b1, 1'b0, 8'h80, 3, p, f);

    // R2: dropping the arm bit for a cycle restarts the clock-line count
    seg(1'b0, 1'b1, 1'b1, 8'h80, N - 2, p, f);
    seg(1'b0, 1'b1, 1'b1, 8'h3F, 1, p, f);
    chk("R2 disarmed no pulse", p, 0);
    seg(1'b0, 1'b1, 1'b1, 8'h80, 2 * N, p, f);
    chk("R2 rearm pulse cycle", f, N);
    seg(1'b1, 1'b1, 1'b0, 8'h00, 3, p, f);

    // R5: busy dropping mid-count clears the data-line count
    seg(1'b1, 1'b0, 1'b1, 8'h40, N - 1, p, f);
    seg(1'b1, 1'b0, 1'b0, 8'h40, 1, p, f);
    seg(1'b1, 1'b0, 1'b1, 8'h40, 2 * N, p, f);
    chk("R5 busy restart pulse cycle", f, N);
    chk("R7 data single pulse", p, 1);

    summary();
  end
endmodule